// File: doc/BRIEF.md
# Load data alignment formatter

This block sits between a core's load path and its register file write port. The memory side has already fetched the naturally aligned container that holds the addressed data: a word, a halfword or a byte. The block takes that raw container, the low bits of the access address, the access size, a signed flag and a core-variant select. From these it builds the 32-bit value that the register receives.

Misaligned loads never fault here. A word load is rotated right by whole bytes according to the byte offset. Two core variants are modelled, and they handle halfwords differently. On the legacy variant an unsigned halfword at an odd address is rotated, and a signed halfword at an odd address degrades to a sign-extended load of its upper byte. On the newer variant address bit 0 is forced to zero for halfwords, so they are never rotated.

The variant select is held static during operation. Each load is presented for one cycle with a `load_valid` strobe. The formatted value and a matching valid flag appear one clock later and are held until the next strobe.

Top module: `ldfmt_align`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `result_valid` is 0.
- R2: `result_valid` is high in exactly the cycle after a cycle in which `load_valid` was high. When `load_valid` is low, `result` keeps its previous value, whatever the other inputs do.
- R3: With `acc_size` 2 (word) or 3 (treated as word), `result` is `raw_data` rotated right by 8 × `addr_lo[1:0]` bits. `is_signed` and `new_variant` have no effect on word loads.
- R4: With `acc_size` 0 (byte) and `is_signed` 0, `result` is `raw_data[7:0]` zero-extended. Address bits are ignored.
- R5: With `acc_size` 0 and `is_signed` 1, `result` is `raw_data[7:0]` sign-extended from bit 7.
- R6: With `acc_size` 1 (halfword), `is_signed` 0 and `new_variant` 0, `result` is `raw_data[15:0]` zero-extended to 32 bits and then rotated right by 8 × `addr_lo[0]`.
- R7: With `acc_size` 1, `is_signed` 0 and `new_variant` 1, `result` is `raw_data[15:0]` zero-extended, with no rotation, for every `addr_lo`.
- R8: With `acc_size` 1, `is_signed` 1, `new_variant` 0 and `addr_lo[0]` 1, `result` is `raw_data[15:8]` sign-extended from its bit 7.
- R9: With `acc_size` 1 and `is_signed` 1, where either `addr_lo[0]` is 0 or `new_variant` is 1, `result` is `raw_data[15:0]` sign-extended from bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | One-cycle strobe marking a load to format |
| raw_data | input | 32 | Aligned container from memory; byte in [7:0], halfword in [15:0] |
| addr_lo | input | 2 | Low address bits of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| is_signed | input | 1 | Sign-extend byte and halfword loads |
| new_variant | input | 1 | 0 legacy variant, 1 newer variant; static |
| result_valid | output | 1 | Formatted value valid, one cycle after the strobe |
| result | output | 32 | Formatted register write value |

## Verification
The bench sweeps every size code, signed flag, variant and two-bit offset. It uses data patterns whose bytes differ in sign, so a wrong lane or a wrong extension bit changes the result. The corner cases are the odd-address signed halfword on the legacy variant and the odd-address unsigned halfword. In the first, a design that does not degrade to the upper byte would sign-extend the whole halfword. In the second, a design that confuses the variants would either rotate on the newer variant or skip the rotation on the legacy one. It also checks rotation direction on misaligned words, where a left rotate puts the wrong byte in the low lane. It checks that `addr_lo[1]` leaves byte and halfword loads untouched and that a missing strobe holds the previous result.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  // Access size codes as seen on the acc_size port.
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // Extension applied to the (possibly pre-shifted) container.
  typedef enum logic [2:0] {
    EXT_NONE = 3'd0,
    EXT_ZB   = 3'd1,
    EXT_SB   = 3'd2,
    EXT_ZH   = 3'd3,
    EXT_SH   = 3'd4
  } ext_mode_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;

endpackage

// File: rtl/ldfmt_decode.sv
module ldfmt_decode
  import ldfmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned AW    = $clog2(LANES)
) (
  input  logic [AW-1:0] addr_lo,
  input  logic [1:0]    acc_size,
  input  logic          is_signed,
  input  logic          new_variant,
  output ext_mode_e     ext_mode,
  output logic          take_upper,
  output logic [AW-1:0] rot_amt,
  output logic          word_misaligned,
  output logic          half_rotated,
  output logic          half_degraded,
  output logic          half_forced
);

  acc_size_e size_q;
  logic      odd_byte;

  assign size_q   = acc_size_e'(acc_size);
  assign odd_byte = addr_lo[0];

  always_comb begin
    ext_mode   = EXT_NONE;
    take_upper = 1'b0;
    rot_amt    = '0;
    unique case (size_q)
      SZ_BYTE: begin
        ext_mode = is_signed ? EXT_SB : EXT_ZB;
      end
      SZ_HALF: begin
        if (is_signed) begin
          if (!new_variant && odd_byte) begin
            take_upper = 1'b1;
            ext_mode   = EXT_SB;
          end else begin
            ext_mode   = EXT_SH;
          end
        end else begin
          ext_mode = EXT_ZH;
          rot_amt  = new_variant ? '0 : AW'(odd_byte);
        end
      end
      default: begin
        rot_amt = addr_lo;
      end
    endcase
  end

  // Named events for the checker.
  assign word_misaligned = (size_q == SZ_WORD || size_q == SZ_WIDE) && (addr_lo != '0);
  assign half_rotated    = (size_q == SZ_HALF) && !is_signed && !new_variant && odd_byte;
  assign half_degraded   = (size_q == SZ_HALF) && is_signed && !new_variant && odd_byte;
  assign half_forced     = (size_q == SZ_HALF) && new_variant && odd_byte;

endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend
  import ldfmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic              take_upper,
  input  ext_mode_e         ext_mode,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] src;

  function automatic logic [DATA_W-1:0] widen_byte(input logic [DATA_W-1:0] v, input logic sgn);
    logic fill;
    fill = sgn & v[BYTE_W-1];
    return {{(DATA_W-BYTE_W){fill}}, v[BYTE_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] widen_half(input logic [DATA_W-1:0] v, input logic sgn);
    logic fill;
    fill = sgn & v[HALF_W-1];
    return {{(DATA_W-HALF_W){fill}}, v[HALF_W-1:0]};
  endfunction

  // Degraded signed halfword: bring the upper byte down to lane 0.
  assign src = take_upper ? (din >> BYTE_W) : din;

  always_comb begin
    unique case (ext_mode)
      EXT_ZB:  dout = widen_byte(src, 1'b0);
      EXT_SB:  dout = widen_byte(src, 1'b1);
      EXT_ZH:  dout = widen_half(src, 1'b0);
      EXT_SH:  dout = widen_half(src, 1'b1);
      default: dout = src;
    endcase
  end

endmodule

// File: rtl/ldfmt_rotate.sv
module ldfmt_rotate
  import ldfmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned AW    = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AW-1:0]     amt,
  output logic [DATA_W-1:0] dout
);

  // Right rotate by whole bytes: output lane k takes input lane (k+amt) mod LANES.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AW-1:0] src_lane;
    assign src_lane = AW'(k) + amt;
    assign dout[k*BYTE_W +: BYTE_W] = din[src_lane*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/ldfmt_outreg.sv
module ldfmt_outreg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] next_value,
  output logic              result_valid,
  output logic [DATA_W-1:0] result
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      result       <= '0;
    end else begin
      result_valid <= load_valid;
      if (load_valid) begin
        result <= next_value;
      end
    end
  end

endmodule

// File: rtl/ldfmt_align.sv
module ldfmt_align
  import ldfmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned AW    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [AW-1:0]     addr_lo,
  input  logic [1:0]        acc_size,
  input  logic              is_signed,
  input  logic              new_variant,
  output logic              result_valid,
  output logic [DATA_W-1:0] result
);

  ext_mode_e         ext_mode;
  logic              take_upper;
  logic [AW-1:0]     rot_amt;
  logic [DATA_W-1:0] extended;
  logic [DATA_W-1:0] formatted;

  // Event wires brought out for the checker.
  logic word_misaligned;
  logic half_rotated;
  logic half_degraded;
  logic half_forced;

  ldfmt_decode #(.DATA_W(DATA_W)) u_decode (
    .addr_lo         (addr_lo),
    .acc_size        (acc_size),
    .is_signed       (is_signed),
    .new_variant     (new_variant),
    .ext_mode        (ext_mode),
    .take_upper      (take_upper),
    .rot_amt         (rot_amt),
    .word_misaligned (word_misaligned),
    .half_rotated    (half_rotated),
    .half_degraded   (half_degraded),
    .half_forced     (half_forced)
  );

  ldfmt_extend #(.DATA_W(DATA_W)) u_extend (
    .din        (raw_data),
    .take_upper (take_upper),
    .ext_mode   (ext_mode),
    .dout       (extended)
  );

  // Halfwords are extended first and then rotated, as the legacy variant does.
  ldfmt_rotate #(.DATA_W(DATA_W)) u_rotate (
    .din  (extended),
    .amt  (rot_amt),
    .dout (formatted)
  );

  ldfmt_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_valid   (load_valid),
    .next_value   (formatted),
    .result_valid (result_valid),
    .result       (result)
  );

endmodule

// File: rtl/ldfmt_align_chk.sv
module ldfmt_align_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_valid,
  input logic [DATA_W-1:0] raw_data,
  input logic [AW-1:0]     addr_lo,
  input logic [1:0]        acc_size,
  input logic              is_signed,
  input logic              new_variant,
  input logic              result_valid,
  input logic [DATA_W-1:0] result,
  input logic              word_misaligned,
  input logic              half_rotated,
  input logic              half_degraded,
  input logic              half_forced
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> result_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |=> (!result_valid && $stable(result)));

  assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && acc_size[1] && !word_misaligned && addr_lo == '0) |=> (result == $past(raw_data)));

  assert_byte_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && acc_size == 2'd0 && !is_signed) |=> (result[DATA_W-1:8] == '0));

  assert_byte_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && acc_size == 2'd0 && is_signed) |=>
      (result[DATA_W-1:8] == {(DATA_W-8){$past(raw_data[7])}}));

  assert_half_rotated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && half_rotated) |=>
      (result[7:0] == $past(raw_data[15:8]) && result[DATA_W-1:DATA_W-8] == $past(raw_data[7:0])));

  assert_half_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && half_forced && !is_signed) |=>
      (result == {{(DATA_W-16){1'b0}}, $past(raw_data[15:0])}));

  assert_half_degraded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && half_degraded) |=>
      (result[7:0] == $past(raw_data[15:8]) && result[DATA_W-1:8] == {(DATA_W-8){$past(raw_data[15])}}));

  assert_half_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && acc_size == 2'd1 && is_signed && (new_variant || !addr_lo[0])) |=>
      (result[15:0] == $past(raw_data[15:0]) && result[DATA_W-1:16] == {(DATA_W-16){$past(raw_data[15])}}));

  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_misaligned, half_rotated, half_degraded}));

  // Reset state is checked one edge into reset.
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (result == '0 && !result_valid)));

endmodule

bind ldfmt_align ldfmt_align_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .load_valid      (load_valid),
  .raw_data        (raw_data),
  .addr_lo         (addr_lo),
  .acc_size        (acc_size),
  .is_signed       (is_signed),
  .new_variant     (new_variant),
  .result_valid    (result_valid),
  .result          (result),
  .word_misaligned (word_misaligned),
  .half_rotated    (half_rotated),
  .half_degraded   (half_degraded),
  .half_forced     (half_forced)
);

// File: tb/ldfmt_align_test.sv
`timescale 1ns/1ps
module ldfmt_align_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic [31:0] raw_data = '0;
  logic [1:0]  addr_lo = '0;
  logic [1:0]  acc_size = '0;
  logic        is_signed = 1'b0;
  logic        new_variant = 1'b0;
  logic        result_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ldfmt_align uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_valid   (load_valid),
    .raw_data     (raw_data),
    .addr_lo      (addr_lo),
    .acc_size     (acc_size),
    .is_signed    (is_signed),
    .new_variant  (new_variant),
    .result_valid (result_valid),
    .result       (result)
  );

  // Reference written from the requirements, byte by byte.
  function automatic logic [31:0] expect_value(input logic [31:0] raw, input logic [1:0] a,
                                               input logic [1:0] sz, input logic sg, input logic nv);
    logic [7:0] b0, b1, b2, b3;
    b0 = raw[7:0]; b1 = raw[15:8]; b2 = raw[23:16]; b3 = raw[31:24];
    if (sz == 2'd0) begin
      return sg ? {{24{b0[7]}}, b0} : {24'h0, b0};
    end else if (sz == 2'd1) begin
      if (nv || !a[0]) return sg ? {{16{b1[7]}}, b1, b0} : {16'h0, b1, b0};
      else if (sg)     return {{24{b1[7]}}, b1};
      else             return {b0, 16'h0, b1};
    end else begin
      case (a)
        2'd0:    return {b3, b2, b1, b0};
        2'd1:    return {b0, b3, b2, b1};
        2'd2:    return {b1, b0, b3, b2};
        default: return {b2, b1, b0, b3};
      endcase
    end
  endfunction

  function automatic string tag_for(input logic [1:0] a, input logic [1:0] sz,
                                    input logic sg, input logic nv);
    if (sz == 2'd0) return sg ? "R5" : "R4";
    if (sz == 2'd1) begin
      if (!sg) return nv ? "R7" : "R6";
      return (!nv && a[0]) ? "R8" : "R9";
    end
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one load, sample one cycle later away from the edge.
  task automatic do_load(input logic [31:0] raw, input logic [1:0] a, input logic [1:0] sz,
                         input logic sg, input logic nv);
    @(negedge clk);
    raw_data = raw; addr_lo = a; acc_size = sz; is_signed = sg; new_variant = nv;
    load_valid = 1'b1;
    @(negedge clk);
    load_valid = 1'b0;
    check(tag_for(a, sz, sg, nv), result, expect_value(raw, a, sz, sg, nv));
    check("R2", {31'h0, result_valid}, 32'h1);
  endtask

  task automatic sweep(input logic [1:0] sz, input logic [31:0] raw);
    for (int nv = 0; nv < 2; nv++)
      for (int sg = 0; sg < 2; sg++)
        for (int a = 0; a < 4; a++)
          do_load(raw, 2'(a), sz, 1'(sg), 1'(nv));
  endtask

  task automatic test_reset_r1();
    @(negedge clk);
    check("R1", result, 32'h0);
    check("R1", {31'h0, result_valid}, 32'h0);
  endtask

  task automatic test_words_r3();
    sweep(2'd2, 32'h1234_5678);
    sweep(2'd3, 32'hF1E2_83C4);
    sweep(2'd2, 32'h80FF_7F01);
  endtask

  task automatic test_bytes_r4_r5();
    sweep(2'd0, 32'h1234_5678);
    sweep(2'd0, 32'hF1E2_83C4);
  endtask

  task automatic test_halves_r6_r9();
    sweep(2'd1, 32'h1234_5678);
    sweep(2'd1, 32'hF1E2_83C4);
    sweep(2'd1, 32'h80FF_7F01);
    sweep(2'd1, 32'h0000_00FF);
  endtask

  task automatic test_hold_r2();
    logic [31:0] held;
    do_load(32'hCAFE_BABE, 2'd1, 2'd2, 1'b0, 1'b0);
    held = result;
    @(negedge clk);
    raw_data = 32'h0BAD_F00D; addr_lo = 2'd3; acc_size = 2'd0; is_signed = 1'b1;
    @(negedge clk);
    check("R2", result, held);
    check("R2", {31'h0, result_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_r1();
    rst_n = 1'b1;
    test_words_r3();
    test_bytes_r4_r5();
    test_halves_r6_r9();
    test_hold_r2();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule